// File: doc/BRIEF.md
# PHY PLL Configuration Sequencer

This block is a hardware sequencer that brings a PHY's internal PLL from idle to locked, and takes it back to idle. It is the only master on a small register-mapped PLL controller. On an init request it wakes the PLL if it is parked, looks up the divider settings for the reference clock from a built-in table, and writes them field by field with read-modify-write accesses. It then strobes the go register and polls for lock under a cycle-count timeout. On an exit request it parks the PLL and waits for the regulator and oscillator power-down flags. The sequence branches on the link mode. For SATA, init leaves an already-locked PLL alone and exit ends with a pulse on a soft-reset line. For PCIe, the PLL is never touched.

The controller sits behind a simple request/acknowledge port: the block holds `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` until `bus_ack`, and read data is taken from `bus_rdata` in the acknowledge cycle. Completion is one `done` pulse, with `error` high in that same cycle when the operation failed.

States and transitions: `S_IDLE` goes to `S_CHECK` on an init request, or to `S_SLEEP_RD` on an exit request (straight to `S_DONE` when no PLL is present). `S_CHECK` goes to `S_DONE` (no PLL), `S_FAIL` (no table entry) or `S_WAKE_RD`. `S_WAKE_RD` reads the idle flag and goes to `S_WAKE_WR` if it is set, else to `S_LOCKED_RD`. `S_WAKE_WR` clears the flag and goes to `S_WAKE_POLL`. That state goes to `S_LOCKED_RD` on lock, or to `S_FAIL` on timeout. `S_LOCKED_RD` goes to `S_DONE` for a locked SATA PLL, else to `S_PRG_RD`. `S_PRG_RD` and `S_PRG_WR` alternate over the five fields, then go to `S_GO_WR`. `S_GO_WR` goes to `S_LOCK_POLL`, which ends in `S_DONE` on lock or in `S_FAIL` on timeout. Exit runs `S_SLEEP_RD`, then `S_SLEEP_WR`, then `S_PWDN_POLL`. `S_PWDN_POLL` goes to `S_SRST_HI` and `S_SRST_LO` (SATA) or to `S_DONE`, or to `S_FAIL` on timeout. `S_DONE` and `S_FAIL` return to `S_IDLE`.

Top module: `pll_cfg_seq`

## Requirements
- R1: After reset, `done`, `error`, `pll_srst` and `bus_req` are low and the block waits in idle.
- R2: Mode encoding: 0 is USB, 1 is SATA, 2 and 3 mean no PLL (PCIe). Rate codes 0 to 5 select a 12, 16.8, 19.2, 20, 26 or 38.4 MHz reference. Each mode has its own table of (M, N, DCO select, SD, fractional M). The fields sit in config1 (0x0C) bits 8:1 for N and bits 20:9 for M, config2 (0x10) bits 3:1 for DCO select, config3 (0x14) bits 17:10 for SD, and config4 (0x20) bits 17:0 for fractional M.
- R3: Every field write is read-modify-write, so bits outside the field keep their value. Every access goes to status 0x04, go 0x08 or one of the four config addresses, and is held stable until acknowledged.
- R4: Programming writes N, then DCO select, then M, then fractional M, then SD, and then writes 1 to go (0x08).
- R5: After go, the block reads status until bit 1 (lock) is set, then completes without error.
- R6: On init, if config2 bit 0 (idle) is set, the block first clears it and waits for lock. A timeout in that wait completes with error.
- R7: An init in SATA mode that finds status bit 1 set completes without any write. USB mode reprograms in the same situation.
- R8: A rate code of 6 or 7 makes init complete with error and no bus access at all.
- R9: If lock is not seen within TIMEOUT_CYCLES of the start of a wait, the operation completes with error.
- R10: Exit sets config2 bit 0, then waits for status bits 15 and 16 to be set together. A timeout in that wait completes with error.
- R11: A successful SATA exit ends with `pll_srst` high for one cycle and then low. No other mode or operation drives it.
- R12: In PCIe mode, both init and exit complete without error and make no bus access.
- R13: Completion is a one-cycle `done` pulse, and `error` is high only together with `done`.
- R14: Start requests that arrive while an operation is running are ignored. When both requests arrive together in idle, init wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_init | input | 1 | Request to configure and lock the PLL |
| start_exit | input | 1 | Request to park the PLL |
| mode | input | 2 | Link mode: 0 USB, 1 SATA, 2/3 PCIe |
| rate_code | input | 3 | Reference clock rate code |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Failure flag, valid with done |
| pll_srst | output | 1 | PLL soft-reset control pulse |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | 8 | Register byte offset |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access accepted |

## Verification
The assertions check on every cycle the bus protocol and the completion signals. Requests stay stable until acknowledged and only mapped addresses are used. Go is always written with 1. `done` and the soft-reset line are single-cycle pulses, `error` only appears with `done`, and reset clears the outputs. The bench scenarios are the only place to see the sequence itself. These cover the table values landing in the right bit ranges with the other bits preserved, and the order of the writes. They also cover the mode branches (a locked SATA PLL left alone, PCIe doing nothing, the SATA reset pulse), the timeouts and the requests ignored while busy.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int RATE_W  = 3;
    localparam int N_STEPS = 5;
    localparam int STEP_W  = $clog2(N_STEPS);

    localparam logic [ADDR_W-1:0] A_STAT = 8'h04;
    localparam logic [ADDR_W-1:0] A_GO   = 8'h08;
    localparam logic [ADDR_W-1:0] A_CFG1 = 8'h0C;
    localparam logic [ADDR_W-1:0] A_CFG2 = 8'h10;
    localparam logic [ADDR_W-1:0] A_CFG3 = 8'h14;
    localparam logic [ADDR_W-1:0] A_CFG4 = 8'h20;

    localparam int BIT_PARK  = 0;   // config2: PLL parked
    localparam int BIT_LOCK  = 1;   // status: locked
    localparam int BIT_LDOOFF = 15; // status: regulator down
    localparam int BIT_OSCOFF = 16; // status: oscillator down

    localparam logic [1:0] MODE_USB  = 2'd0;
    localparam logic [1:0] MODE_SATA = 2'd1;

    typedef struct packed {
        logic [11:0] m;
        logic [7:0]  n;
        logic [2:0]  dco;
        logic [7:0]  sd;
        logic [17:0] mf;
    } div_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] mask;
        logic [4:0]        shift;
    } step_t;

    typedef enum logic [4:0] {
        S_IDLE, S_CHECK,
        S_WAKE_RD, S_WAKE_WR, S_WAKE_POLL,
        S_LOCKED_RD, S_PRG_RD, S_PRG_WR, S_GO_WR, S_LOCK_POLL,
        S_SLEEP_RD, S_SLEEP_WR, S_PWDN_POLL,
        S_SRST_HI, S_SRST_LO,
        S_DONE, S_FAIL
    } seq_state_e;

    function automatic div_t mk_div(input int m, input int n, input int dco,
                                    input int sd, input int mf);
        div_t d;
        d.m   = 12'(m);
        d.n   = 8'(n);
        d.dco = 3'(dco);
        d.sd  = 8'(sd);
        d.mf  = 18'(mf);
        return d;
    endfunction

    // Field order of programming: N, DCO, M, fractional M, SD.
    function automatic step_t step_info(input logic [STEP_W-1:0] idx);
        step_t s;
        unique case (idx)
            3'd0:    s = '{addr: A_CFG1, mask: 32'h0000_01FE, shift: 5'd1};
            3'd1:    s = '{addr: A_CFG2, mask: 32'h0000_000E, shift: 5'd1};
            3'd2:    s = '{addr: A_CFG1, mask: 32'h001F_FE00, shift: 5'd9};
            3'd3:    s = '{addr: A_CFG4, mask: 32'h0003_FFFF, shift: 5'd0};
            default: s = '{addr: A_CFG3, mask: 32'h0003_FC00, shift: 5'd10};
        endcase
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] step_value(input div_t d,
                                                     input logic [STEP_W-1:0] idx);
        unique case (idx)
            3'd0:    return DATA_W'(d.n);
            3'd1:    return DATA_W'(d.dco);
            3'd2:    return DATA_W'(d.m);
            3'd3:    return DATA_W'(d.mf);
            default: return DATA_W'(d.sd);
        endcase
    endfunction

endpackage

// File: rtl/pll_rate_table.sv
module pll_rate_table
    import pll_cfg_pkg::*;
(
    input  logic [1:0]        mode,
    input  logic [RATE_W-1:0] rate,
    output div_t              div,
    output logic              hit
);

    always_comb begin
        hit = 1'b1;
        div = '0;
        if (mode == MODE_SATA) begin
            unique case (rate)
                3'd0:    div = mk_div(625, 4, 4, 6, 0);
                3'd1:    div = mk_div(625, 6, 4, 7, 0);
                3'd2:    div = mk_div(625, 7, 4, 6, 0);
                3'd3:    div = mk_div(750, 9, 4, 6, 0);
                3'd4:    div = mk_div(750, 12, 4, 6, 0);
                3'd5:    div = mk_div(625, 15, 4, 6, 0);
                default: hit = 1'b0;
            endcase
        end else begin
            unique case (rate)
                3'd0:    div = mk_div(1250, 5, 4, 20, 0);
                3'd1:    div = mk_div(3125, 20, 4, 20, 0);
                3'd2:    div = mk_div(1172, 8, 4, 20, 65537);
                3'd3:    div = mk_div(1000, 7, 4, 10, 0);
                3'd4:    div = mk_div(1250, 12, 4, 20, 0);
                3'd5:    div = mk_div(3125, 47, 4, 20, 92843);
                default: hit = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/pll_wait_timer.sv
module pll_wait_timer #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign expired = (cnt_q >= CW'(LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pll_field_merge.sv
module pll_field_merge
    import pll_cfg_pkg::*;
(
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] field_val,
    input  logic [DATA_W-1:0] mask,
    input  logic [4:0]        shift,
    output logic [DATA_W-1:0] new_word
);

    assign new_word = (old_word & ~mask) | ((field_val << shift) & mask);

endmodule

// File: rtl/pll_cfg_seq.sv
module pll_cfg_seq
    import pll_cfg_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_init,
    input  logic              start_exit,
    input  logic [1:0]        mode,
    input  logic [RATE_W-1:0] rate_code,
    output logic              done,
    output logic              error,
    output logic              pll_srst,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS - 1);

    seq_state_e        state_q, state_d;
    logic [STEP_W-1:0] step_q;
    logic [DATA_W-1:0] shadow_q;
    logic [1:0]        mode_q;
    logic [RATE_W-1:0] rate_q;

    div_t              div;
    logic              hit;
    step_t             cur_step;
    logic [DATA_W-1:0] merged;
    logic              tmr_clr, tmr_en, tmr_exp;
    logic              is_sata, no_pll, rd_done, wr_done;

    assign is_sata  = (mode_q == MODE_SATA);
    assign no_pll   = mode_q[1];
    assign cur_step = step_info(step_q);
    assign rd_done  = bus_req && !bus_we && bus_ack;
    assign wr_done  = bus_req && bus_we && bus_ack;
    assign tmr_en   = (state_q == S_WAKE_POLL) || (state_q == S_LOCK_POLL) ||
                      (state_q == S_PWDN_POLL);

    pll_rate_table u_table (
        .mode (mode_q),
        .rate (rate_q),
        .div  (div),
        .hit  (hit)
    );

    pll_field_merge u_merge (
        .old_word  (shadow_q),
        .field_val (step_value(div, step_q)),
        .mask      (cur_step.mask),
        .shift     (cur_step.shift),
        .new_word  (merged)
    );

    pll_wait_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .en      (tmr_en),
        .expired (tmr_exp)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request latch, read shadow, field step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            rate_q   <= '0;
            shadow_q <= '0;
            step_q   <= '0;
        end else begin
            if (state_q == S_IDLE && (start_init || start_exit)) begin
                mode_q <= mode;
                rate_q <= rate_code;
            end
            if (rd_done) begin
                shadow_q <= bus_rdata;
            end
            if (state_q == S_LOCKED_RD) begin
                step_q <= '0;
            end else if (state_q == S_PRG_WR && wr_done && step_q != LAST_STEP) begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        tmr_clr = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_init) begin
                    state_d = S_CHECK;
                end else if (start_exit) begin
                    state_d = mode[1] ? S_DONE : S_SLEEP_RD;
                end
            end
            S_CHECK: begin
                if (no_pll)    state_d = S_DONE;
                else if (!hit) state_d = S_FAIL;
                else           state_d = S_WAKE_RD;
            end
            S_WAKE_RD: begin
                if (rd_done) state_d = bus_rdata[BIT_PARK] ? S_WAKE_WR : S_LOCKED_RD;
            end
            S_WAKE_WR: begin
                if (wr_done) begin
                    state_d = S_WAKE_POLL;
                    tmr_clr = 1'b1;
                end
            end
            S_WAKE_POLL: begin
                if (rd_done) begin
                    if (bus_rdata[BIT_LOCK]) state_d = S_LOCKED_RD;
                    else if (tmr_exp)        state_d = S_FAIL;
                end
            end
            S_LOCKED_RD: begin
                if (rd_done) state_d = (is_sata && bus_rdata[BIT_LOCK]) ? S_DONE : S_PRG_RD;
            end
            S_PRG_RD: begin
                if (rd_done) state_d = S_PRG_WR;
            end
            S_PRG_WR: begin
                if (wr_done) state_d = (step_q == LAST_STEP) ? S_GO_WR : S_PRG_RD;
            end
            S_GO_WR: begin
                if (wr_done) begin
                    state_d = S_LOCK_POLL;
                    tmr_clr = 1'b1;
                end
            end
            S_LOCK_POLL: begin
                if (rd_done) begin
                    if (bus_rdata[BIT_LOCK]) state_d = S_DONE;
                    else if (tmr_exp)        state_d = S_FAIL;
                end
            end
            S_SLEEP_RD: begin
                if (rd_done) state_d = S_SLEEP_WR;
            end
            S_SLEEP_WR: begin
                if (wr_done) begin
                    state_d = S_PWDN_POLL;
                    tmr_clr = 1'b1;
                end
            end
            S_PWDN_POLL: begin
                if (rd_done) begin
                    if (bus_rdata[BIT_LDOOFF] && bus_rdata[BIT_OSCOFF])
                        state_d = is_sata ? S_SRST_HI : S_DONE;
                    else if (tmr_exp)
                        state_d = S_FAIL;
                end
            end
            S_SRST_HI: state_d = S_SRST_LO;
            S_SRST_LO: state_d = S_DONE;
            S_DONE:    state_d = S_IDLE;
            S_FAIL:    state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        done      = 1'b0;
        error     = 1'b0;
        pll_srst  = 1'b0;
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = A_STAT;
        bus_wdata = '0;
        unique case (state_q)
            S_IDLE, S_CHECK, S_SRST_LO: ;
            S_WAKE_RD, S_SLEEP_RD: begin
                bus_req  = 1'b1;
                bus_addr = A_CFG2;
            end
            S_WAKE_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = A_CFG2;
                bus_wdata = shadow_q & ~(DATA_W'(1) << BIT_PARK);
            end
            S_SLEEP_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = A_CFG2;
                bus_wdata = shadow_q | (DATA_W'(1) << BIT_PARK);
            end
            S_WAKE_POLL, S_LOCKED_RD, S_LOCK_POLL, S_PWDN_POLL: begin
                bus_req  = 1'b1;
                bus_addr = A_STAT;
            end
            S_PRG_RD: begin
                bus_req  = 1'b1;
                bus_addr = cur_step.addr;
            end
            S_PRG_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = cur_step.addr;
                bus_wdata = merged;
            end
            S_GO_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = A_GO;
                bus_wdata = DATA_W'(1);
            end
            S_SRST_HI: pll_srst = 1'b1;
            S_DONE:    done = 1'b1;
            S_FAIL: begin
                done  = 1'b1;
                error = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/pll_cfg_seq_chk.sv
module pll_cfg_seq_chk
    import pll_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              error,
    input logic              pll_srst,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ack
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!done && !error && !bus_req && !pll_srst));

    assert_addr_mapped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_addr == A_STAT || bus_addr == A_GO || bus_addr == A_CFG1 ||
                     bus_addr == A_CFG2 || bus_addr == A_CFG3 || bus_addr == A_CFG4));

    assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

    assert_go_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == A_GO) |-> (bus_wdata == DATA_W'(1)));

    assert_srst_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pll_srst |=> !pll_srst);

    assert_srst_no_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pll_srst |-> !bus_req);

    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_error_with_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

endmodule

bind pll_cfg_seq pll_cfg_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .error     (error),
    .pll_srst  (pll_srst),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack)
);

// File: tb/pll_cfg_seq_bench.sv
`timescale 1ns/1ps
module pll_cfg_seq_bench;

    localparam int TMO      = 40;
    localparam int LOCK_DLY = 6;
    localparam int PWDN_DLY = 9;

    // {mode, rate, M, N, DCO, SD, fracM}
    localparam logic [53:0] VEC [6] = '{
        {2'd0, 3'd0, 12'd1250, 8'd5,  3'd4, 8'd20, 18'd0},
        {2'd0, 3'd2, 12'd1172, 8'd8,  3'd4, 8'd20, 18'd65537},
        {2'd0, 3'd5, 12'd3125, 8'd47, 3'd4, 8'd20, 18'd92843},
        {2'd1, 3'd1, 12'd625,  8'd6,  3'd4, 8'd7,  18'd0},
        {2'd1, 3'd3, 12'd750,  8'd9,  3'd4, 8'd6,  18'd0},
        {2'd0, 3'd3, 12'd1000, 8'd7,  3'd4, 8'd10, 18'd0}
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        start_init = 1'b0, start_exit = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [2:0]  rate_code = 3'd0;
    logic        done, error, pll_srst, bus_req, bus_we, bus_ack;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;

    pll_cfg_seq #(.TIMEOUT_CYCLES(TMO)) u_pll_cfg_seq (
        .clk(clk), .rst_n(rst_n), .start_init(start_init), .start_exit(start_exit),
        .mode(mode), .rate_code(rate_code), .done(done), .error(error),
        .pll_srst(pll_srst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    // PLL controller model
    logic [31:0] mem [0:15];
    logic [7:0]  wr_log [0:15];
    logic        lock_bit, pwdn_bit, hang_lock, hang_pwdn, srst_prev;
    int          lock_cnt, pwdn_cnt, wr_cnt, req_cnt, srst_rises, done_cnt;
    int          n_checks = 0, n_errors = 0;

    assign bus_ack   = bus_req;
    assign bus_rdata = (bus_addr == 8'h04) ?
                       {15'd0, pwdn_bit, pwdn_bit, 13'd0, lock_bit, 1'b0} :
                       mem[bus_addr[5:2]];

    always @(posedge clk) begin
        srst_prev <= pll_srst;
        if (pll_srst && !srst_prev) srst_rises <= srst_rises + 1;
        if (done) done_cnt <= done_cnt + 1;
        if (lock_cnt > 0) begin
            lock_cnt <= lock_cnt - 1;
            if (lock_cnt == 1 && !hang_lock) lock_bit <= 1'b1;
        end
        if (pwdn_cnt > 0) begin
            pwdn_cnt <= pwdn_cnt - 1;
            if (pwdn_cnt == 1 && !hang_pwdn) pwdn_bit <= 1'b1;
        end
        if (bus_req) begin
            req_cnt <= req_cnt + 1;
            if (bus_we) begin
                mem[bus_addr[5:2]] <= bus_wdata;
                if (wr_cnt < 16) wr_log[wr_cnt[3:0]] <= bus_addr;
                wr_cnt <= wr_cnt + 1;
                if (bus_addr == 8'h08) lock_cnt <= LOCK_DLY;
                if (bus_addr == 8'h10) begin
                    if (bus_wdata[0]) begin
                        lock_bit <= 1'b0;
                        lock_cnt <= 0;
                        pwdn_cnt <= PWDN_DLY;
                    end else begin
                        pwdn_bit <= 1'b0;
                        if (mem[4][0]) lock_cnt <= LOCK_DLY;
                    end
                end
            end
        end
    end

    task automatic clear_model(input logic [31:0] pre, input logic parked, input logic locked);
        for (int k = 0; k < 16; k++) mem[k] = pre;
        mem[4]     = {pre[31:1], parked};
        mem[2]     = 32'd0;
        lock_bit   = locked;
        pwdn_bit   = 1'b0;
        lock_cnt   = 0;
        pwdn_cnt   = 0;
        hang_lock  = 1'b0;
        hang_pwdn  = 1'b0;
        wr_cnt     = 0;
        req_cnt    = 0;
        srst_rises = 0;
        done_cnt   = 0;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_done(output bit d, output bit e);
        d = 1'b0;
        e = 1'b0;
        for (int k = 0; k < 1000 && !d; k++) begin
            if (done) begin
                d = 1'b1;
                e = error;
            end else begin
                @(negedge clk);
            end
        end
        if (d) begin
            @(negedge clk);
            chk(!done, "R13 done width", 64'(done), 64'd0);
        end
    endtask

    task automatic run_op(input bit is_exit, input logic [1:0] m, input logic [2:0] r,
                          output bit d, output bit e);
        @(negedge clk);
        mode = m;
        rate_code = r;
        if (is_exit) start_exit = 1'b1; else start_init = 1'b1;
        @(negedge clk);
        start_init = 1'b0;
        start_exit = 1'b0;
        wait_done(d, e);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [53:0] v;
        logic [31:0] pre, e1, e2, e3, e4;
        logic [7:0]  order [6];
        bit          d, e;

        clear_model(32'h0, 1'b0, 1'b0);
        srst_prev = 1'b0;
        repeat (3) @(negedge clk);
        chk(!done && !error, "R1 reset done/error", {62'd0, done, error}, 64'd0);
        chk(!bus_req && !pll_srst, "R1 reset bus/srst", {62'd0, bus_req, pll_srst}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_req && !done, "R1 idle after reset", {62'd0, bus_req, done}, 64'd0);

        order = '{8'h0C, 8'h10, 8'h0C, 8'h20, 8'h14, 8'h08};

        // Vector table: programming with each table entry
        for (int i = 0; i < 6; i++) begin
            v   = VEC[i];
            pre = 32'hA5A5_5A5A ^ (32'h0101_1010 * 32'(i));
            clear_model(pre, 1'b0, 1'b0);
            run_op(1'b0, v[53:52], v[51:49], d, e);
            chk(d && !e, "R5 init completes", {62'd0, d, e}, 64'd2);
            chk(wr_cnt == 6, "R4 write count", 64'(wr_cnt), 64'd6);
            for (int k = 0; k < 6; k++)
                chk(wr_log[k] == order[k], "R4 write order", 64'(wr_log[k]), 64'(order[k]));
            e1 = (pre & ~32'h001F_FFFE) | (32'(v[36:29]) << 1) | (32'(v[48:37]) << 9);
            e2 = (pre & ~32'h0000_000F) | (32'(v[28:26]) << 1);
            e3 = (pre & ~32'h0003_FC00) | (32'(v[25:18]) << 10);
            e4 = (pre & ~32'h0003_FFFF) | 32'(v[17:0]);
            chk(mem[3] == e1, "R2 R3 config1 N/M", 64'(mem[3]), 64'(e1));
            chk(mem[4] == e2, "R2 R3 config2 DCO", 64'(mem[4]), 64'(e2));
            chk(mem[5] == e3, "R2 R3 config3 SD", 64'(mem[5]), 64'(e3));
            chk(mem[8] == e4, "R2 R3 config4 fracM", 64'(mem[8]), 64'(e4));
            chk(mem[2] == 32'd1, "R4 go written", 64'(mem[2]), 64'd1);
        end

        // R6: parked PLL woken first
        clear_model(32'h1234_5670, 1'b1, 1'b0);
        run_op(1'b0, 2'd0, 3'd4, d, e);
        chk(d && !e, "R6 wake completes", {62'd0, d, e}, 64'd2);
        chk(wr_cnt == 7, "R6 wake write count", 64'(wr_cnt), 64'd7);
        chk(wr_log[0] == 8'h10, "R6 first write unparks", 64'(wr_log[0]), 64'h10);
        chk(mem[4][0] == 1'b0, "R6 park bit cleared", 64'(mem[4][0]), 64'd0);

        // R6: wake lock timeout
        clear_model(32'h0, 1'b1, 1'b0);
        hang_lock = 1'b1;
        run_op(1'b0, 2'd0, 3'd0, d, e);
        chk(d && e, "R6 wake timeout error", {62'd0, d, e}, 64'd3);
        chk(wr_cnt == 1, "R6 no programming after wake timeout", 64'(wr_cnt), 64'd1);

        // R7: SATA already locked
        clear_model(32'hFFFF_0000, 1'b0, 1'b1);
        run_op(1'b0, 2'd1, 3'd0, d, e);
        chk(d && !e, "R7 SATA locked completes", {62'd0, d, e}, 64'd2);
        chk(wr_cnt == 0, "R7 SATA locked no writes", 64'(wr_cnt), 64'd0);

        // R7: USB reprograms even when locked
        clear_model(32'hFFFF_0000, 1'b0, 1'b1);
        run_op(1'b0, 2'd0, 3'd0, d, e);
        chk(wr_cnt == 6, "R7 USB locked reprograms", 64'(wr_cnt), 64'd6);

        // R8: invalid rate codes
        clear_model(32'h0, 1'b0, 1'b0);
        run_op(1'b0, 2'd0, 3'd6, d, e);
        chk(d && e, "R8 rate 6 error", {62'd0, d, e}, 64'd3);
        chk(req_cnt == 0, "R8 rate 6 no access", 64'(req_cnt), 64'd0);
        clear_model(32'h0, 1'b1, 1'b0);
        run_op(1'b0, 2'd1, 3'd7, d, e);
        chk(d && e, "R8 rate 7 error", {62'd0, d, e}, 64'd3);
        chk(req_cnt == 0, "R8 rate 7 no access", 64'(req_cnt), 64'd0);

        // R12: PCIe skips the PLL
        clear_model(32'h0, 1'b1, 1'b0);
        run_op(1'b0, 2'd2, 3'd6, d, e);
        chk(d && !e, "R12 PCIe init", {62'd0, d, e}, 64'd2);
        run_op(1'b1, 2'd2, 3'd0, d, e);
        chk(d && !e, "R12 PCIe exit", {62'd0, d, e}, 64'd2);
        chk(req_cnt == 0 && srst_rises == 0, "R12 PCIe no access", 64'(req_cnt), 64'd0);

        // R9: lock timeout after go
        clear_model(32'h0, 1'b0, 1'b0);
        hang_lock = 1'b1;
        run_op(1'b0, 2'd0, 3'd1, d, e);
        chk(d && e, "R9 lock timeout error", {62'd0, d, e}, 64'd3);
        chk(mem[2] == 32'd1, "R9 go issued before timeout", 64'(mem[2]), 64'd1);

        // R10 / R11: USB exit
        clear_model(32'hCAFE_0000, 1'b0, 1'b1);
        run_op(1'b1, 2'd0, 3'd0, d, e);
        chk(d && !e, "R10 USB exit completes", {62'd0, d, e}, 64'd2);
        chk(mem[4] == 32'hCAFE_0001, "R10 park bit set, rest kept", 64'(mem[4]), 64'hCAFE0001);
        chk(srst_rises == 0, "R11 no soft reset for USB", 64'(srst_rises), 64'd0);

        // R11: SATA exit pulse
        clear_model(32'h0, 1'b0, 1'b1);
        run_op(1'b1, 2'd1, 3'd0, d, e);
        chk(d && !e, "R11 SATA exit completes", {62'd0, d, e}, 64'd2);
        chk(srst_rises == 1 && !pll_srst, "R11 one soft reset pulse", 64'(srst_rises), 64'd1);

        // R10: power-down timeout
        clear_model(32'h0, 1'b0, 1'b1);
        hang_pwdn = 1'b1;
        run_op(1'b1, 2'd1, 3'd0, d, e);
        chk(d && e, "R10 power-down timeout error", {62'd0, d, e}, 64'd3);
        chk(srst_rises == 0, "R11 no pulse after failed exit", 64'(srst_rises), 64'd0);

        // R14: requests while busy are ignored
        clear_model(32'h0, 1'b0, 1'b0);
        @(negedge clk);
        mode = 2'd0; rate_code = 3'd4; start_init = 1'b1;
        @(negedge clk);
        start_init = 1'b0;
        repeat (3) @(negedge clk);
        start_init = 1'b1; start_exit = 1'b1;
        @(negedge clk);
        start_init = 1'b0; start_exit = 1'b0;
        wait_done(d, e);
        repeat (30) @(negedge clk);
        chk(done_cnt == 1, "R14 single completion", 64'(done_cnt), 64'd1);
        chk(wr_cnt == 6, "R14 busy requests ignored", 64'(wr_cnt), 64'd6);
        chk(mem[4][0] == 1'b0, "R14 exit while busy ignored", 64'(mem[4][0]), 64'd0);

        // R14: both requests together, init wins
        clear_model(32'h0, 1'b0, 1'b0);
        @(negedge clk);
        mode = 2'd0; rate_code = 3'd0; start_init = 1'b1; start_exit = 1'b1;
        @(negedge clk);
        start_init = 1'b0; start_exit = 1'b0;
        wait_done(d, e);
        chk(wr_cnt == 6 && mem[4][0] == 1'b0, "R14 init has priority", 64'(wr_cnt), 64'd6);

        finish_run();
    end

endmodule